// File: doc/BRIEF.md
# Iterative Hi/Lo Integer Divider

This block divides one 32-bit integer by another over a fixed number of clock cycles and leaves the outcome in two result registers: the quotient in LO and the remainder in HI. A one-cycle start pulse launches an operation. The pulse carries a mode select (signed or unsigned) and the two operands. The block then raises busy, develops one quotient bit per cycle by restoring division on operand magnitudes, and spends one final cycle applying the signs and writing the results.

A done pulse marks the cycle in which HI and LO take their new values. Between operations both registers stay readable at the ports, much as move-from-HI and move-from-LO reads would see them. A zero divisor never traps and never yields arbitrary data: it always clears both registers. Multiplication, pipeline interlocks and exception reporting belong to other blocks.

Top module: `hilo_divider`

## Requirements
- R1: With mode_signed=0, both operands are unsigned 32-bit values. After the operation, LO holds floor(dividend/divisor) and HI holds dividend mod divisor.
- R2: With mode_signed=1, both operands are two's-complement. The quotient truncates toward zero and goes to LO. The remainder takes the sign of the dividend (or is zero) and goes to HI.
- R3: A divisor of zero sets both HI and LO to 0 in either mode.
- R4: In signed mode, 0x80000000 divided by 0xFFFFFFFF gives LO=0x80000000 and HI=0. Nothing else is signalled.
- R5: A start accepted at clock edge N raises busy after edge N. After edge N+33, done is high for exactly one cycle, busy is low, and HI and LO hold the new values. Busy stays high over edges N+1 to N+32.
- R6: A start pulse while busy is high is ignored. The running operation completes with its original operands and timing.
- R7: HI and LO keep their previous values at every edge other than the one that raises done.
- R8: After reset, busy=0, done=0, HI=0 and LO=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, taken only while idle |
| mode_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 32 | Numerator, sampled with start |
| divisor | input | 32 | Denominator, sampled with start |
| busy | output | 1 | High while an operation is in flight |
| done | output | 1 | One-cycle pulse when HI/LO are written |
| hi | output | 32 | Remainder register |
| lo | output | 32 | Quotient register |

## Verification
The embedded properties assume start is a clean, known level at every sampled edge. They also assume operands are stable only at the edge that accepts them; nothing later is relied on. The bench drives every input on the falling edge, so start is never ambiguous at a rising edge. It deliberately toggles start and changes the operands while busy, to confirm that the latched copies alone decide the result. Reset is held over several edges before the first operation, so the state-based properties begin from a defined state.

// File: rtl/hilo_div_pkg.sv
package hilo_div_pkg;
  localparam int DEF_WIDTH = 32;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ITER = 2'd1,
    PH_FIX  = 2'd2
  } div_phase_e;
endpackage

// File: rtl/hilo_div_ctrl.sv
module hilo_div_ctrl
  import hilo_div_pkg::*;
#(
  parameter int WIDTH = DEF_WIDTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic iter_en,
  output logic fix_en,
  output logic busy
);
  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  div_phase_e phase_q;
  logic [CNT_W-1:0] step_q;

  assign accept  = start && (phase_q == PH_IDLE);
  assign iter_en = (phase_q == PH_ITER);
  assign fix_en  = (phase_q == PH_FIX);
  assign busy    = (phase_q != PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (accept) begin
          phase_q <= PH_ITER;
          step_q  <= '0;
        end
        PH_ITER: begin
          step_q <= step_q + 1'b1;
          if (step_q == LAST_STEP) phase_q <= PH_FIX;
        end
        PH_FIX:  phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R5
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  // R5
  fix_follows_iter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_en |-> $past(iter_en));
  // R6
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fix_en) |=> busy);
  // R6
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);
endmodule

// File: rtl/hilo_div_datapath.sv
module hilo_div_datapath #(
  parameter int WIDTH = hilo_div_pkg::DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             iter_en,
  input  logic             mode_signed,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quo_mag,
  output logic [WIDTH-1:0] rem_mag,
  output logic             quo_neg,
  output logic             rem_neg,
  output logic             dsr_zero
);
  logic [WIDTH-1:0] dsr_q;

  function automatic logic [WIDTH-1:0] magnitude(input logic [WIDTH-1:0] v,
                                                  input logic sgn);
    return (sgn && v[WIDTH-1]) ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [2*WIDTH-1:0] restore_step(input logic [WIDTH-1:0] r,
                                                       input logic [WIDTH-1:0] q,
                                                       input logic [WIDTH-1:0] d);
    logic [WIDTH:0] trial;
    logic [WIDTH:0] diff;
    logic           ge;
    trial = {r, q[WIDTH-1]};
    diff  = trial - {1'b0, d};
    ge    = (trial >= {1'b0, d});
    return {(ge ? diff[WIDTH-1:0] : trial[WIDTH-1:0]), q[WIDTH-2:0], ge};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo_mag  <= '0;
      rem_mag  <= '0;
      dsr_q    <= '0;
      quo_neg  <= 1'b0;
      rem_neg  <= 1'b0;
      dsr_zero <= 1'b0;
    end else if (load) begin
      quo_mag  <= magnitude(dividend, mode_signed);
      rem_mag  <= '0;
      dsr_q    <= magnitude(divisor, mode_signed);
      quo_neg  <= mode_signed && (dividend[WIDTH-1] ^ divisor[WIDTH-1]);
      rem_neg  <= mode_signed && dividend[WIDTH-1];
      dsr_zero <= (divisor == '0);
    end else if (iter_en) begin
      {rem_mag, quo_mag} <= restore_step(rem_mag, quo_mag, dsr_q);
    end
  end

  // R1
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsr_q != '0) |-> (rem_mag < dsr_q));
  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsr_zero |-> (dsr_q == '0));
endmodule

// File: rtl/hilo_div_result.sv
module hilo_div_result #(
  parameter int WIDTH = hilo_div_pkg::DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fix_en,
  input  logic [WIDTH-1:0] quo_mag,
  input  logic [WIDTH-1:0] rem_mag,
  input  logic             quo_neg,
  input  logic             rem_neg,
  input  logic             dsr_zero,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo,
  output logic             done
);
  function automatic logic [WIDTH-1:0] apply_sign(input logic [WIDTH-1:0] m,
                                                   input logic neg,
                                                   input logic zero);
    if (zero) return '0;
    return neg ? (~m + 1'b1) : m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi   <= '0;
      lo   <= '0;
      done <= 1'b0;
    end else begin
      done <= fix_en;
      if (fix_en) begin
        lo <= apply_sign(quo_mag, quo_neg, dsr_zero);
        hi <= apply_sign(rem_mag, rem_neg, dsr_zero);
      end
    end
  end

  // R7
  hold_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fix_en |=> ($stable(hi) && $stable(lo)));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_en && dsr_zero) |=> (hi == '0 && lo == '0 && done));
endmodule

// File: rtl/hilo_divider.sv
module hilo_divider #(
  parameter int WIDTH = hilo_div_pkg::DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_signed,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hi,
  output logic [WIDTH-1:0] lo
);
  logic             accept, iter_en, fix_en;
  logic [WIDTH-1:0] quo_mag, rem_mag;
  logic             quo_neg, rem_neg, dsr_zero;

  hilo_div_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .iter_en(iter_en), .fix_en(fix_en), .busy(busy)
  );

  hilo_div_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .iter_en(iter_en),
    .mode_signed(mode_signed), .dividend(dividend), .divisor(divisor),
    .quo_mag(quo_mag), .rem_mag(rem_mag), .quo_neg(quo_neg),
    .rem_neg(rem_neg), .dsr_zero(dsr_zero)
  );

  hilo_div_result #(.WIDTH(WIDTH)) res_i (
    .clk(clk), .rst_n(rst_n), .fix_en(fix_en), .quo_mag(quo_mag),
    .rem_mag(rem_mag), .quo_neg(quo_neg), .rem_neg(rem_neg),
    .dsr_zero(dsr_zero), .hi(hi), .lo(lo), .done(done)
  );

  // R5
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/hilo_divider_tb.sv
module hilo_divider_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode_signed = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done;
  logic [31:0] hi, lo;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hilo_divider dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_signed(mode_signed),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .hi(hi), .lo(lo)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, got, exp);
    end
  endtask

  // Bench-side model: quotient and remainder from language arithmetic.
  task automatic model(input bit sgn, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] eq, output logic [31:0] er);
    longint sa, sb;
    if (b == 0) begin eq = 0; er = 0; end
    else if (!sgn) begin eq = a / b; er = a % b; end
    else begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      eq = 32'(sa / sb);
      er = 32'(sa % sb);
    end
  endtask

  // Launch on a falling edge; optionally poke start again while busy.
  task automatic run_div(input string req, input bit sgn, input logic [31:0] a,
                         input logic [31:0] b, input bit poke);
    logic [31:0] eq, er, old_hi, old_lo;
    model(sgn, a, b, eq, er);
    old_hi = hi; old_lo = lo;
    @(negedge clk);
    start = 1'b1; mode_signed = sgn; dividend = a; divisor = b;
    @(negedge clk);                           // edge N passed
    start = 1'b0;
    check("R5", "busy after start", {31'd0, busy}, 32'd1);
    for (int i = 1; i <= 32; i++) begin
      if (poke && i == 5) begin
        start = 1'b1; mode_signed = ~sgn; dividend = 32'h1234_5678; divisor = 32'd3;
      end else if (poke && i == 6) begin
        start = 1'b0; dividend = 32'hDEAD_BEEF;
      end
      @(negedge clk);                         // edge N+i passed
      if (i == 16 || i == 32) begin
        check("R7", "hi held", hi, old_hi);
        check("R7", "lo held", lo, old_lo);
      end
    end
    check("R5", "done low before last edge", {31'd0, done}, 32'd0);
    check("R5", "busy high at edge N+32", {31'd0, busy}, 32'd1);
    @(negedge clk);                           // edge N+33 passed
    check("R5", "done pulse", {31'd0, done}, 32'd1);
    check("R5", "busy dropped", {31'd0, busy}, 32'd0);
    check(req, "lo quotient", lo, eq);
    check(req, "hi remainder", hi, er);
    @(negedge clk);
    check("R5", "done single cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic test_reset;
    check("R8", "busy", {31'd0, busy}, 32'd0);
    check("R8", "done", {31'd0, done}, 32'd0);
    check("R8", "hi", hi, 32'd0);
    check("R8", "lo", lo, 32'd0);
  endtask

  task automatic test_unsigned;
    run_div("R1", 1'b0, 32'd100, 32'd7, 1'b0);
    run_div("R1", 1'b0, 32'hFFFF_FFFF, 32'd16, 1'b0);
    run_div("R1", 1'b0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
    run_div("R1", 1'b0, 32'd5, 32'd9, 1'b0);
  endtask

  task automatic test_signed;
    run_div("R2", 1'b1, -32'sd7, 32'd2, 1'b0);
    run_div("R2", 1'b1, 32'd7, -32'sd2, 1'b0);
    run_div("R2", 1'b1, -32'sd100, -32'sd9, 1'b0);
    run_div("R2", 1'b1, 32'd12345678, 32'd1000, 1'b0);
  endtask

  task automatic test_zero;
    run_div("R3", 1'b0, 32'hCAFE_F00D, 32'd0, 1'b0);
    run_div("R3", 1'b1, -32'sd55, 32'd0, 1'b0);
  endtask

  task automatic test_min_neg;
    run_div("R4", 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic test_busy_start;
    run_div("R6", 1'b0, 32'd1000, 32'd33, 1'b1);
    run_div("R6", 1'b1, -32'sd1000, 32'd33, 1'b1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_unsigned();
    test_signed();
    test_zero();
    test_min_neg();
    test_busy_start();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule